// File: doc/BRIEF.md
# Data-Enable Recovery for Sync-Only Parallel Video

This block sits between a parallel 24-bit RGB source and a per-channel TMDS encoder. The source drives a pixel clock, horizontal sync and vertical sync, but no data-enable line. The block counts pixel clocks from each horizontal sync leading edge and lines from each vertical sync leading edge. From those two positions and the configured timing it rebuilds an active-video flag that is exact to the clock. The encoder can then choose between pixel symbols and control symbols on every cycle.

The picture width and height, the front porch, sync width and back porch of each axis, and the sync polarity of each axis are parameters. The defaults describe a 1280x720 frame at 60 Hz, which uses a pixel clock of about 74.25 MHz: 1650 clocks per line and 750 lines per frame. The block does not generate timing. It only follows the incoming syncs. It confirms that the measured line length and frame height match the parameters before it lets the active flag through. Any deviation withdraws the flag at once.

The pixel stream cannot be paused, so there is no valid/ready pair. Every clock carries one pixel and one pair of sync samples, and every clock produces one output pixel. The block applies no back-pressure and accepts none. The downstream encoder must take one pixel per clock.

Top module: `vde_recover`

## Requirements
- R1: The red, green and blue buses, both syncs, the active flag and the lock flag all leave exactly two clock edges after the edge that samples the matching input. Nothing is reordered.
- R2: A sync becomes "asserted" when it matches its axis polarity. The first asserted sample after a deasserted one is a leading edge, and that sample is position 0 of the line. The line index goes up by one at every horizontal leading edge. A vertical leading edge sets the line index to 0.
- R3: The active flag is high exactly when three conditions hold: the pixel position lies in [H_SYNC+H_BACK, H_SYNC+H_BACK+H_ACTIVE), the line index lies in [V_SYNC+V_BACK, V_SYNC+V_BACK+V_ACTIVE), and lock was held before that sample.
- R4: A frame is clean when three conditions hold: it starts at a vertical leading edge, every line in it is exactly H_FRONT+H_SYNC+H_BACK+H_ACTIVE clocks, and it has exactly the vertical total of lines. Lock is set on the vertical leading edge that closes the second consecutive clean frame.
- R5: When a horizontal leading edge closes a line of the wrong length, lock clears on that sample. The active flag is low for every later pixel until lock returns.
- R6: A vertical leading edge that closes a frame of the wrong height clears lock.
- R7: Lock clears at once in two cases: the line index reaches the vertical total without a vertical leading edge, or the pixel position reaches the horizontal total without a horizontal leading edge.
- R8: An active-low synchronous reset clears the counters, the lock state and all outputs, so the active flag and the lock flag read 0.
- R9: The active flag is never high while lock is low.
- R10: Sync polarity is chosen per axis by HS_ACTIVE_HIGH and VS_ACTIVE_HIGH. The sync outputs keep the input polarity.
- R11: After reset, lines and frames that were not opened by a leading edge are not judged. Reaching lock takes two clean frames after the first vertical leading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_r | input | 8 | Red sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| in_hs | input | 1 | Horizontal sync from the source |
| in_vs | input | 1 | Vertical sync from the source |
| out_r | output | 8 | Red, delayed two clocks |
| out_g | output | 8 | Green, delayed two clocks |
| out_b | output | 8 | Blue, delayed two clocks |
| out_hs | output | 1 | Horizontal sync, same polarity, delayed two clocks |
| out_vs | output | 1 | Vertical sync, same polarity, delayed two clocks |
| out_de | output | 1 | Rebuilt active-video flag |
| locked | output | 1 | Timing matches the parameters |

## Verification
An off-by-one in the pixel counter or in the window decode shifts or stretches the active flag by a clock. That shows on the first active line after lock, two clocks after the offending sample. A lock state that trusts a dirty or partial frame raises the lock flag one frame too early. A lock state that ignores a mismatch keeps the active flag high through a corrupted line, which is visible within one line of the fault. The bench steps a behavioural model beside the design and compares every output on every clock. Any such drift is therefore reported in the cycle where it first reaches the ports.

// File: rtl/vde_pkg.sv
package vde_pkg;
  parameter int unsigned CH_W = 8;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/vde_edge.sv
// Normalises one sync to "asserted = 1" in the first pipeline stage and
// flags its leading edge.
module vde_edge #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic sync_on,
  output logic lead
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_on <= 1'b0;
      prev    <= 1'b0;
    end else begin
      sync_on <= (sync_raw == ACTIVE_HIGH);
      prev    <= sync_on;
    end
  end

  assign lead = sync_on & ~prev;
endmodule

// File: rtl/vde_axis_cnt.sv
// Position counter for one axis: restarts on a leading edge, saturates at
// the axis total, decodes the active window and judges the closed span.
module vde_axis_cnt #(
  parameter int TOTAL = 1650,
  parameter int START = 260,
  parameter int LEN   = 1280,
  parameter int CW    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic in_win,
  output logic at_cap,
  output logic len_bad
);
  localparam logic [CW-1:0] CAP  = CW'(TOTAL);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);
  localparam logic [CW-1:0] LO   = CW'(START);
  localparam logic [CW-1:0] HI   = CW'(START + LEN);

  logic [CW-1:0] q;
  logic [CW-1:0] pos;
  logic          seen;

  always_comb begin
    if (restart)                    pos = '0;
    else if (advance && q != CAP)   pos = q + CW'(1);
    else                            pos = q;
  end

  assign in_win  = (pos >= LO) && (pos < HI);
  assign at_cap  = (pos == CAP);
  assign len_bad = restart & seen & (q != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      seen <= 1'b0;
    end else begin
      q    <= pos;
      seen <= seen | restart;
    end
  end
endmodule

// File: rtl/vde_lock.sv
// Counts consecutive clean frames; any mismatch clears the count at once.
module vde_lock #(
  parameter int LOCK_FRAMES = 2,
  parameter int GW          = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic v_lead,
  input  logic mismatch,
  input  logic height_bad,
  output logic locked
);
  localparam logic [GW-1:0] FULL = GW'(LOCK_FRAMES);

  logic [GW-1:0] good;
  logic          dirty;
  logic          vseen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good  <= '0;
      dirty <= 1'b0;
      vseen <= 1'b0;
    end else if (v_lead) begin
      vseen <= 1'b1;
      dirty <= 1'b0;
      if (mismatch || (vseen && (dirty || height_bad))) good <= '0;
      else if (vseen && good != FULL)                   good <= good + GW'(1);
    end else if (mismatch) begin
      dirty <= 1'b1;
      good  <= '0;
    end
  end

  assign locked = (good == FULL);
endmodule

// File: rtl/vde_recover.sv
module vde_recover #(
  parameter int H_ACTIVE       = 1280,
  parameter int H_FRONT        = 110,
  parameter int H_SYNC         = 40,
  parameter int H_BACK         = 220,
  parameter int V_ACTIVE       = 720,
  parameter int V_FRONT        = 5,
  parameter int V_SYNC         = 5,
  parameter int V_BACK         = 20,
  parameter bit HS_ACTIVE_HIGH = 1'b1,
  parameter bit VS_ACTIVE_HIGH = 1'b1,
  parameter int LOCK_FRAMES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  input  logic       in_hs,
  input  logic       in_vs,
  output logic [7:0] out_r,
  output logic [7:0] out_g,
  output logic [7:0] out_b,
  output logic       out_hs,
  output logic       out_vs,
  output logic       out_de,
  output logic       locked
);
  import vde_pkg::*;

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HCW     = $clog2(H_TOTAL + 1);
  localparam int VCW     = $clog2(V_TOTAL + 1);
  localparam int GW      = $clog2(LOCK_FRAMES + 1);

  // stage A: sampled pixel and normalised syncs
  rgb_t in_pix, a_pix;
  logic h_on, v_on, h_lead, v_lead;
  logic h_win, v_win, h_cap, v_cap, line_bad, height_bad;

  assign in_pix = {in_r, in_g, in_b};

  always_ff @(posedge clk) begin
    if (!rst_n) a_pix <= '0;
    else        a_pix <= in_pix;
  end

  vde_edge #(.ACTIVE_HIGH(HS_ACTIVE_HIGH)) u_hedge (
    .clk(clk), .rst_n(rst_n), .sync_raw(in_hs), .sync_on(h_on), .lead(h_lead)
  );
  vde_edge #(.ACTIVE_HIGH(VS_ACTIVE_HIGH)) u_vedge (
    .clk(clk), .rst_n(rst_n), .sync_raw(in_vs), .sync_on(v_on), .lead(v_lead)
  );

  // pixel position advances every clock, line index on each line start
  vde_axis_cnt #(.TOTAL(H_TOTAL), .START(H_SYNC + H_BACK), .LEN(H_ACTIVE), .CW(HCW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .restart(h_lead), .advance(1'b1),
    .in_win(h_win), .at_cap(h_cap), .len_bad(line_bad)
  );
  vde_axis_cnt #(.TOTAL(V_TOTAL), .START(V_SYNC + V_BACK), .LEN(V_ACTIVE), .CW(VCW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .restart(v_lead), .advance(h_lead),
    .in_win(v_win), .at_cap(v_cap), .len_bad(height_bad)
  );

  vde_lock #(.LOCK_FRAMES(LOCK_FRAMES), .GW(GW)) u_lock (
    .clk(clk), .rst_n(rst_n), .v_lead(v_lead),
    .mismatch(line_bad | h_cap | v_cap), .height_bad(height_bad),
    .locked(locked)
  );

  // stage B: every output leaves through the same register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_r  <= '0;
      out_g  <= '0;
      out_b  <= '0;
      out_hs <= 1'b0;
      out_vs <= 1'b0;
      out_de <= 1'b0;
    end else begin
      out_r  <= a_pix.r;
      out_g  <= a_pix.g;
      out_b  <= a_pix.b;
      out_hs <= ~(h_on ^ HS_ACTIVE_HIGH);
      out_vs <= ~(v_on ^ VS_ACTIVE_HIGH);
      out_de <= h_win & v_win & locked;
    end
  end
endmodule

// File: rtl/vde_recover_chk.sv
module vde_recover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_r,
  input logic [7:0] out_r,
  input logic       out_de,
  input logic       locked,
  input logic       v_lead
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_de && !locked));

  // R1
  pix_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_r == $past(in_r, 2)));

  // R9
  de_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_de |-> locked);

  // R4
  lock_on_vedge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(v_lead));

  // R5
  lock_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !out_de);
endmodule

bind vde_recover vde_recover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_r(in_r), .out_r(out_r),
  .out_de(out_de), .locked(locked), .v_lead(v_lead)
);

// File: tb/vde_recover_tb.sv
module vde_recover_tb;
  localparam int HA = 8, HF = 2, HSW = 3, HB = 4;
  localparam int VA = 4, VF = 1, VSW = 2, VB = 3;
  localparam int HT = HA + HF + HSW + HB;
  localparam int VT = VA + VF + VSW + VB;
  localparam bit HPOL = 1'b0;  // active-low hsync
  localparam bit VPOL = 1'b1;  // active-high vsync

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_hs = !HPOL, in_vs = !VPOL;
  logic [7:0] out_r, out_g, out_b;
  logic out_hs, out_vs, out_de, locked;

  always #4 clk = ~clk;

  vde_recover #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HSW), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VSW), .V_BACK(VB),
    .HS_ACTIVE_HIGH(HPOL), .VS_ACTIVE_HIGH(VPOL), .LOCK_FRAMES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_hs(in_hs), .in_vs(in_vs), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de), .locked(locked)
  );

  typedef struct {
    logic [7:0] r, g, b;
    logic hs, vs, de, lk;
  } exp_t;
  exp_t exq[$];

  int n_checks = 0, n_err = 0, cyc = 0, de_cnt = 0, pix_seq = 0;

  // behavioural reference state
  bit m_hprev, m_vprev, m_hseen, m_vseen, m_dirty, m_lk;
  int m_hc, m_vc, m_good;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_reset();
    m_hprev = 0; m_vprev = 0; m_hseen = 0; m_vseen = 0; m_dirty = 0; m_lk = 0;
    m_hc = 0; m_vc = 0; m_good = 0;
  endtask

  task automatic model_step(input logic hs, input logic vs, output logic de, output logic lk);
    bit hon, von, hl, vl, mism;
    int hp, vp;
    hon = (hs == HPOL); von = (vs == VPOL);
    hl = hon && !m_hprev; vl = von && !m_vprev;
    m_hprev = hon; m_vprev = von;
    mism = 0;
    // R2: leading edge is position 0
    if (hl) begin
      if (m_hseen && m_hc + 1 != HT) mism = 1;  // R5
      m_hseen = 1; hp = 0;
    end else hp = (m_hc < HT) ? m_hc + 1 : m_hc;
    if (vl) vp = 0;
    else if (hl) vp = (m_vc < VT) ? m_vc + 1 : m_vc;
    else vp = m_vc;
    if (hp == HT || vp == VT) mism = 1;  // R7
    de = (hp >= HSW + HB) && (hp < HSW + HB + HA) &&
         (vp >= VSW + VB) && (vp < VSW + VB + VA) && m_lk;
    if (vl) begin
      if (mism || (m_vseen && (m_dirty || m_vc + 1 != VT))) m_good = 0;  // R6
      else if (m_vseen && m_good < 2) m_good++;
      m_vseen = 1; m_dirty = 0;
    end else if (mism) begin
      m_dirty = 1; m_good = 0;
    end
    m_lk = (m_good == 2);
    lk = m_lk;
    m_hc = hp; m_vc = vp;
  endtask

  task automatic tick(input logic hs, input logic vs);
    exp_t e, n;
    @(negedge clk);
    if (exq.size() == 2) begin
      e = exq.pop_front();
      chk(out_r == e.r && out_g == e.g && out_b == e.b, "R1", "rgb",
          int'({out_r, out_g, out_b}), int'({e.r, e.g, e.b}));
      chk(out_hs == e.hs, "R10", "out_hs", int'(out_hs), int'(e.hs));
      chk(out_vs == e.vs, "R10", "out_vs", int'(out_vs), int'(e.vs));
      chk(out_de == e.de, "R3", "out_de", int'(out_de), int'(e.de));
      chk(locked == e.lk, "R4", "locked", int'(locked), int'(e.lk));
    end
    de_cnt += int'(out_de);
    rst_n = 1'b1;
    pix_seq++;
    n.r = pix_seq[7:0]; n.g = pix_seq[15:8] ^ 8'h5a; n.b = ~pix_seq[7:0];
    n.hs = hs; n.vs = vs;
    in_r = n.r; in_g = n.g; in_b = n.b; in_hs = hs; in_vs = vs;
    model_step(hs, vs, n.de, n.lk);
    exq.push_back(n);
  endtask

  task automatic frame(input int first_line, input int nlines, input int bad_line,
                       input int bad_len, input bit vs_en);
    for (int l = first_line; l < first_line + nlines; l++) begin
      int len;
      len = (l == bad_line) ? bad_len : HT;
      for (int p = 0; p < len; p++)
        tick((p < HSW) ? HPOL : !HPOL, (vs_en && l < VSW) ? VPOL : !VPOL);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_hs = !HPOL; in_vs = !VPOL;
    repeat (3) @(negedge clk);
    // R8
    chk(out_de == 1'b0, "R8", "out_de in reset", int'(out_de), 0);
    chk(locked == 1'b0, "R8", "locked in reset", int'(locked), 0);
    chk(out_r == 8'h00, "R8", "out_r in reset", int'(out_r), 0);
    chk(out_hs == 1'b0, "R8", "out_hs in reset", int'(out_hs), 0);
    exq.delete();
    model_reset();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    de_cnt = 0;
    frame(0, VT, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b0, "R4", "after one clean frame", int'(locked), 0);
    chk(de_cnt == 0, "R9", "de count while unlocked", de_cnt, 0);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b1, "R4", "after two clean frames", int'(locked), 1);
    de_cnt = 0;
    frame(0, VT, -1, 0, 1);
    chk(de_cnt == HA * VA, "R3", "de count in locked frame", de_cnt, HA * VA);

    // R5: a short line
    de_cnt = 0;
    frame(0, VT, 5, HT - 2, 1);
    chk(locked == 1'b0, "R5", "after short line", int'(locked), 0);
    chk(de_cnt < HA * VA, "R5", "de count cut short", de_cnt, HA);
    frame(0, VT, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b0, "R4", "one clean frame after fault", int'(locked), 0);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b1, "R4", "relock after line fault", int'(locked), 1);

    // R6: a short frame
    frame(0, VT - 2, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b0, "R6", "after short frame", int'(locked), 0);
    frame(0, VT, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b1, "R6", "relock after short frame", int'(locked), 1);

    // R7: vsync missing for a frame
    frame(0, VT, -1, 0, 0);
    chk(locked == 1'b0, "R7", "after missing vsync", int'(locked), 0);
    frame(0, VT, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b1, "R7", "relock after missing vsync", int'(locked), 1);

    // R11: reset in mid-frame, then a partial frame with no vsync edge
    frame(0, 4, -1, 0, 1);
    do_reset();
    frame(3, VT - 3, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b0, "R11", "partial frame not counted", int'(locked), 0);
    frame(0, VT, -1, 0, 1);
    chk(locked == 1'b1, "R11", "lock after two full frames", int'(locked), 1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule